// File: doc/BRIEF.md
# Low-Power Mode Controller

This block decides when the processor core, the peripherals and the oscillator receive clock. Software writes two bits, a sleep bit and a deep-stop bit, through a one-cycle write strobe. Setting the sleep bit stops only the core clock: the oscillator and the peripheral clocks (timers, serial port, interrupt logic) keep running, so an enabled interrupt can wake the core. Execution then resumes at the point where it stopped. Setting the deep-stop bit turns off every clock, the oscillator included. Only a qualified hardware reset leaves that state.

The block runs on an always-on reference clock, counted in machine cycles of `MC_CLKS` clocks each. The hardware reset pin counts only once it has stayed high for `RST_MCS` machine cycles in a row. The block then raises a qualified system reset. That reset clears the control bits and forces all clock enables on. Stored data is not this block's concern: it only gates clocks, so memory and core state are left as they were. The three enables drive clock gating cells outside the block.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `rst_n` is low and after it is released, the block is in run state: `core_clk_en`, `periph_clk_en` and `osc_en` are 1, `sleep_flag`, `stop_flag` and `sys_rst` are 0.
- R2: A write in run state with `wr_sleep`=1 and `wr_stop`=0 sets `sleep_flag` and drops `core_clk_en` to 0 from the next clock edge. `periph_clk_en` and `osc_en` stay 1.
- R3: A write in run state with `wr_stop`=1 drops all three enables to 0 from the next edge, whatever the value of `wr_sleep` (deep-stop wins). Both flags take the written values.
- R4: In sleep state, `irq`=1 at a clock edge returns `core_clk_en` to 1 and clears `sleep_flag` at that edge.
- R5: `irq` has no effect in deep-stop state or in run state: enables and flags are unchanged.
- R6: Writes in sleep or deep-stop state are ignored: flags and enables are unchanged.
- R7: `sys_rst` rises at the clock edge on which `hw_rst` has been sampled high for HOLD = `MC_CLKS`*`RST_MCS` consecutive edges (24 by default). A shorter pulse has no effect. `sys_rst` falls on the first edge that samples `hw_rst` low.
- R8: While `sys_rst` is 1, all three enables are 1. One edge after `sys_rst` rises, both flags are 0 and the state is run. This is the only way out of deep-stop, and it also ends sleep.
- R9: A write in run state with both bits 0 keeps the block in run state with both flags 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| hw_rst | input | 1 | Hardware reset pin, active high, unqualified |
| wr | input | 1 | One-cycle write strobe for the control bits |
| wr_sleep | input | 1 | Written value of the sleep bit |
| wr_stop | input | 1 | Written value of the deep-stop bit |
| irq | input | 1 | Enabled interrupt request |
| core_clk_en | output | 1 | Core clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| sleep_flag | output | 1 | Stored sleep bit |
| stop_flag | output | 1 | Stored deep-stop bit |
| sys_rst | output | 1 | Qualified system reset |

## Verification
The hardest situation to reach is a reset pulse that stops just one edge short of qualification while the block is in deep-stop. The stimulus drives `hw_rst` for HOLD-1 cycles and expects no exit. It then holds the pin for the full window and expects the exit on the exact edge. Interrupts and writes are also applied during deep-stop and sleep to show that they do nothing. A behavioural cycle model in the bench predicts every output on every clock.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  typedef enum logic [1:0] {
    PM_RUN   = 2'd0,
    PM_SLEEP = 2'd1,
    PM_STOP  = 2'd2
  } pm_state_e;
endpackage

// File: rtl/pwr_rst_qual.sv
module pwr_rst_qual #(
  parameter int MC_CLKS = 12,
  parameter int RST_MCS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_rst,
  output logic sys_rst
);
  localparam int HOLD = MC_CLKS * RST_MCS;
  localparam int CW   = $clog2(HOLD + 1);
  localparam logic [CW-1:0] HOLD_M1 = CW'(HOLD - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          rst_q, rst_d;

  always_comb begin
    cnt_d = '0;
    rst_d = 1'b0;
    if (hw_rst) begin
      rst_d = (cnt_q == HOLD_M1);
      cnt_d = (cnt_q == HOLD_M1) ? cnt_q : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rst_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rst_q <= rst_d;
    end
  end

  assign sys_rst = rst_q;

  AST_RST_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_rst |=> !sys_rst); // R7
  AST_RST_NEEDS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst) |-> $past(hw_rst)); // R7
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sys_rst,
  input  logic      wr,
  input  logic      wr_sleep,
  input  logic      wr_stop,
  input  logic      irq,
  output pm_state_e state,
  output logic      sleep_flag,
  output logic      stop_flag
);
  pm_state_e st_q, st_d;
  logic      sl_q, sl_d;
  logic      sp_q, sp_d;

  always_comb begin
    st_d = st_q;
    sl_d = sl_q;
    sp_d = sp_q;
    if (sys_rst) begin
      st_d = PM_RUN;
      sl_d = 1'b0;
      sp_d = 1'b0;
    end else begin
      case (st_q)
        PM_RUN: begin
          if (wr) begin
            sl_d = wr_sleep;
            sp_d = wr_stop;
            if (wr_stop)       st_d = PM_STOP;
            else if (wr_sleep) st_d = PM_SLEEP;
          end
        end
        PM_SLEEP: begin
          if (irq) begin
            st_d = PM_RUN;
            sl_d = 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= PM_RUN;
      sl_q <= 1'b0;
      sp_q <= 1'b0;
    end else begin
      st_q <= st_d;
      sl_q <= sl_d;
      sp_q <= sp_d;
    end
  end

  assign state      = st_q;
  assign sleep_flag = sl_q;
  assign stop_flag  = sp_q;

  AST_STOP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PM_RUN && wr && wr_stop && !sys_rst) |=> st_q == PM_STOP); // R3
  AST_WAKE_ON_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PM_SLEEP && irq && !sys_rst) |=> (st_q == PM_RUN && !sl_q)); // R4
  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PM_STOP && !sys_rst) |=> st_q == PM_STOP); // R5
  AST_SLEEP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PM_SLEEP && !irq && !sys_rst) |=> $stable({sl_q, sp_q})); // R6
  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |=> (st_q == PM_RUN && !sl_q && !sp_q)); // R8
endmodule

// File: rtl/pwr_clk_en.sv
module pwr_clk_en
  import pwr_pkg::*;
(
  input  pm_state_e state,
  input  logic      sys_rst,
  output logic      core_en,
  output logic      periph_en,
  output logic      osc_en
);
  always_comb begin
    core_en   = sys_rst || (state == PM_RUN);
    periph_en = sys_rst || (state != PM_STOP);
    osc_en    = sys_rst || (state != PM_STOP);
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_pkg::*;
#(
  parameter int MC_CLKS = 12,
  parameter int RST_MCS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_rst,
  input  logic wr,
  input  logic wr_sleep,
  input  logic wr_stop,
  input  logic irq,
  output logic core_clk_en,
  output logic periph_clk_en,
  output logic osc_en,
  output logic sleep_flag,
  output logic stop_flag,
  output logic sys_rst
);
  pm_state_e state;
  logic      qrst;

  pwr_rst_qual #(.MC_CLKS(MC_CLKS), .RST_MCS(RST_MCS)) u_qual (
    .clk(clk), .rst_n(rst_n), .hw_rst(hw_rst), .sys_rst(qrst)
  );

  pwr_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .sys_rst(qrst), .wr(wr),
    .wr_sleep(wr_sleep), .wr_stop(wr_stop), .irq(irq),
    .state(state), .sleep_flag(sleep_flag), .stop_flag(stop_flag)
  );

  pwr_clk_en u_en (
    .state(state), .sys_rst(qrst), .core_en(core_clk_en),
    .periph_en(periph_clk_en), .osc_en(osc_en)
  );

  assign sys_rst = qrst;

  AST_RESET_RUNS_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |-> (core_clk_en && periph_clk_en && osc_en)); // R8
  AST_OSC_OFF_ONLY_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_en) |-> (stop_flag && !core_clk_en)); // R3
endmodule

// File: tb/pwr_mode_ctrl_test.sv
module pwr_mode_ctrl_test;
  localparam int HOLD = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hw_rst = 1'b0, wr = 1'b0, wr_sleep = 1'b0, wr_stop = 1'b0, irq = 1'b0;
  logic core_clk_en, periph_clk_en, osc_en, sleep_flag, stop_flag, sys_rst;

  int checks = 0;
  int fails  = 0;
  bit live   = 1'b0;

  // behavioural model: 0 run, 1 sleep, 2 deep-stop
  int m_st = 0, m_cnt = 0;
  bit m_rst = 1'b0, m_sl = 1'b0, m_sp = 1'b0;

  always #2.5 clk = ~clk;

  pwr_mode_ctrl uut (
    .clk(clk), .rst_n(rst_n), .hw_rst(hw_rst), .wr(wr), .wr_sleep(wr_sleep),
    .wr_stop(wr_stop), .irq(irq), .core_clk_en(core_clk_en),
    .periph_clk_en(periph_clk_en), .osc_en(osc_en), .sleep_flag(sleep_flag),
    .stop_flag(stop_flag), .sys_rst(sys_rst)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_rst = 0; m_sl = 0; m_sp = 0;
    end else begin
      bit nr;
      nr = hw_rst && (m_cnt >= HOLD - 1);
      m_cnt = hw_rst ? ((m_cnt + 1 > HOLD - 1) ? HOLD - 1 : m_cnt + 1) : 0;
      if (m_rst) begin
        m_st = 0; m_sl = 0; m_sp = 0;
      end else if (m_st == 0 && wr) begin
        m_sl = wr_sleep; m_sp = wr_stop;
        m_st = wr_stop ? 2 : (wr_sleep ? 1 : 0);
      end else if (m_st == 1 && irq) begin
        m_st = 0; m_sl = 0;
      end
      m_rst = nr;
    end
  end

  always @(negedge clk) begin
    if (live) begin
      chk("R2 core_clk_en", core_clk_en, m_rst || m_st == 0);
      chk("R3 periph_clk_en", periph_clk_en, m_rst || m_st != 2);
      chk("R3 osc_en", osc_en, m_rst || m_st != 2);
      chk("R4 sleep_flag", sleep_flag, m_sl);
      chk("R6 stop_flag", stop_flag, m_sp);
      chk("R7 sys_rst", sys_rst, m_rst);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write(input logic s, input logic p);
    @(negedge clk);
    wr = 1'b1; wr_sleep = s; wr_stop = p;
    @(negedge clk);
    wr = 1'b0; wr_sleep = 1'b0; wr_stop = 1'b0;
  endtask

  task automatic pulse_irq(input int n);
    @(negedge clk); irq = 1'b1;
    tick(n);
    irq = 1'b0;
  endtask

  task automatic pin_reset(input int n);
    @(negedge clk); hw_rst = 1'b1;
    tick(n);
    hw_rst = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    tick(3);
    // R1: state while held in reset
    chk("R1 core_clk_en", core_clk_en, 1'b1);
    chk("R1 osc_en", osc_en, 1'b1);
    chk("R1 sleep_flag", sleep_flag, 1'b0);
    chk("R1 sys_rst", sys_rst, 1'b0);
    rst_n = 1'b1;
    live = 1'b1;
    tick(2);

    // R9: write of zeros keeps run
    write(1'b0, 1'b0);
    chk("R9 core_clk_en", core_clk_en, 1'b1);
    tick(2);

    // R2 then R4: sleep and wake
    write(1'b1, 1'b0);
    chk("R2 core_clk_en", core_clk_en, 1'b0);
    chk("R2 osc_en", osc_en, 1'b1);
    tick(3);
    write(1'b1, 1'b1); // R6: ignored in sleep
    chk("R6 stop_flag", stop_flag, 1'b0);
    pulse_irq(1);
    chk("R4 core_clk_en", core_clk_en, 1'b1);
    chk("R4 sleep_flag", sleep_flag, 1'b0);
    pulse_irq(3); // R5: irq in run
    chk("R5 core_clk_en", core_clk_en, 1'b1);

    // R3: deep-stop, irq and writes ignored, short reset ignored
    write(1'b0, 1'b1);
    chk("R3 osc_en", osc_en, 1'b0);
    pulse_irq(4);
    chk("R5 osc_en", osc_en, 1'b0);
    write(1'b0, 1'b0);
    chk("R6 stop_flag", stop_flag, 1'b1);
    pin_reset(HOLD - 1);
    tick(2);
    chk("R7 sys_rst", sys_rst, 1'b0);
    chk("R7 osc_en", osc_en, 1'b0);
    pin_reset(HOLD + 5);
    tick(2);
    chk("R8 osc_en", osc_en, 1'b1);
    chk("R8 stop_flag", stop_flag, 1'b0);

    // R3: both bits, deep-stop wins
    write(1'b1, 1'b1);
    chk("R3 periph_clk_en", periph_clk_en, 1'b0);
    chk("R3 sleep_flag", sleep_flag, 1'b1);
    pin_reset(HOLD);
    chk("R7 sys_rst", sys_rst, 1'b1);
    tick(2);
    chk("R8 sleep_flag", sleep_flag, 1'b0);

    // R8: reset also ends sleep
    write(1'b1, 1'b0);
    pin_reset(HOLD + 2);
    tick(2);
    chk("R8 core_clk_en", core_clk_en, 1'b1);
    tick(4);
    finish_run();
  end
endmodule